// File: doc/BRIEF.md
# Packed JTAG Bit-Bang Engine

This block plays out a short burst of JTAG test-port activity that software has loaded into it word by word. One word sets how many doublets the burst holds; the data words carry those doublets, two bits each, starting at the least significant bit of the first data word. A doublet supplies one TMS bit and one TDI bit. The engine supplies the test clock itself, so each doublet becomes one complete TCK pulse, and the TDO level seen during that pulse is recorded as one bit of a readback buffer.

The TCK high time and low time are equal and set in system clock cycles. The point at which TDO is sampled, counted in cycles from the rise of TCK, can also be set. Both settings sit in the same word-write space as the command words and keep their reset values until they are written. A start strobe launches the burst, a busy flag covers it, and the captured TDO bits are read back as plain 32-bit words with no length word in front.

Top module: `jtag_burst_engine`

## Requirements
- R1: After reset, TCK, TMS, TDI and busy are 0, both readback words are 0, the half-period is 8 cycles and the TDO sample delay is 2 cycles.
- R2: Word-write address map (default parameters): 0 is the doublet count, 1 to 4 are data words (address 1 holds the lowest 32 bits of the doublet stream), 5 is the half-period, 6 is the sample delay. A write to address 7 has no effect.
- R3: Doublet k is formed from bit 2k (TMS) and bit 2k+1 (TDI) of the doublet stream, so each data word holds 16 doublets. TMS and TDI take the doublet's values one cycle before TCK rises and do not change while TCK is high.
- R4: Each doublet gives exactly one TCK pulse: one low setup cycle, then TCK high for H cycles, then low for H cycles, where H is the half-period setting and a setting of 0 counts as 1.
- R5: The TDO bit of a doublet is the TDO level in cycle D of its pulse, where cycle 0 is the first cycle with TCK high and D is the sample-delay setting, limited to at most 2H-1.
- R6: Readback word w (rd_idx = w) returns the TDO bits of doublets 32w to 32w+31, doublet 32w at bit 0; bits for doublets beyond the count read 0.
- R7: An accepted start clears all TDO bits captured by the previous burst.
- R8: Busy rises at the clock edge that samples start and stays high for exactly N x (2H+1) cycles, where N is the doublet count; TCK is low when busy falls.
- R9: While busy is high, word writes and start strobes are ignored.
- R10: A count word of 0 ends at once: busy stays low, TCK never pulses and the readback buffer is cleared. A count word above 57 is taken as 57.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 3 | Word write address |
| wr_data | input | 32 | Word write data |
| start | input | 1 | Start strobe for the loaded burst |
| busy | output | 1 | High while a burst runs |
| rd_idx | input | 1 | TDO readback word select |
| rd_data | output | 32 | Selected TDO readback word |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target |

## Verification
The hardest point to reach from the ports is proof that TDO is taken in exactly cycle D of each pulse and nowhere else. The bench acts as the target: it tracks the cycles since each TCK rise and drives the expected bit on TDO only in cycle D, with its inverse in every other cycle, so a capture one cycle early or late lands the wrong value in the readback. Random half-periods and delays, including delays past 2H-1 and a half-period of 0, exercise the limit, and mid-burst writes and starts are followed by a rerun with no reload to show at the pins that nothing changed.

// File: rtl/jtb_pkg.sv
package jtb_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_CLOCK = 2'd2
    } seq_state_e;
endpackage

// File: rtl/jtb_cmd_regs.sv
module jtb_cmd_regs #(
    parameter int DATA_W    = 32,
    parameter int MAX_DBL   = 57,
    parameter int CMD_WORDS = 4,
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 6,
    parameter int HP_W      = 8,
    parameter int SD_W      = 8,
    parameter int HP_RST    = 8,
    parameter int SD_RST    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        lock,
    output logic [CNT_W-1:0]            count_o,
    output logic [CMD_WORDS*DATA_W-1:0] cmd_bits_o,
    output logic [HP_W-1:0]             half_o,
    output logic [SD_W-1:0]             sdly_o
);
    typedef struct packed {
        logic [CNT_W-1:0]            count;
        logic [CMD_WORDS*DATA_W-1:0] bits;
        logic [HP_W-1:0]             half;
        logic [SD_W-1:0]             sdly;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en && !lock) begin
            if (wr_addr == '0) begin
                // clamp against the whole word, not just the stored bits
                d.count = (wr_data > DATA_W'(MAX_DBL)) ? CNT_W'(MAX_DBL) : wr_data[CNT_W-1:0];
            end
            for (int w = 0; w < CMD_WORDS; w++) begin
                if (wr_addr == ADDR_W'(w + 1)) begin
                    d.bits[w*DATA_W +: DATA_W] = wr_data;
                end
            end
            if (wr_addr == ADDR_W'(CMD_WORDS + 1)) begin
                d.half = wr_data[HP_W-1:0];
            end
            if (wr_addr == ADDR_W'(CMD_WORDS + 2)) begin
                d.sdly = wr_data[SD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.count <= '0;
            q.bits  <= '0;
            q.half  <= HP_W'(HP_RST);
            q.sdly  <= SD_W'(SD_RST);
        end else begin
            q <= d;
        end
    end

    assign count_o    = q.count;
    assign cmd_bits_o = q.bits;
    assign half_o     = q.half;
    assign sdly_o     = q.sdly;
endmodule

// File: rtl/jtb_seq.sv
module jtb_seq
    import jtb_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int BITS_W  = 128,
    parameter int HP_W    = 8,
    parameter int SD_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [BITS_W-1:0] cmd_bits_i,
    input  logic [HP_W-1:0]   half_i,
    input  logic [SD_W-1:0]   sdly_i,
    output logic              busy_o,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdi_o,
    output logic              clr_o,
    output logic              cap_en_o,
    output logic [CNT_W-1:0]  cap_idx_o
);
    localparam int PH_W  = (HP_W + 1 > SD_W) ? HP_W + 1 : SD_W;
    localparam int IDX_W = $clog2(BITS_W);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] idx;
        logic [PH_W-1:0]  ph;
        logic             busy;
        logic             tck;
        logic             tms;
        logic             tdi;
    } seq_t;

    seq_t q, d;

    logic [PH_W-1:0]  h_eff, last_hi, last_ph, sd_eff;
    logic [CNT_W-1:0] nxt_idx;
    logic [IDX_W-1:0] bpos;

    always_comb begin
        h_eff   = (half_i == '0) ? PH_W'(1) : PH_W'(half_i);
        last_hi = h_eff - PH_W'(1);
        last_ph = (h_eff << 1) - PH_W'(1);
        sd_eff  = (PH_W'(sdly_i) > last_ph) ? last_ph : PH_W'(sdly_i);
        nxt_idx = q.idx + CNT_W'(1);
        bpos    = IDX_W'({nxt_idx, 1'b0});

        d        = q;
        clr_o    = 1'b0;
        cap_en_o = 1'b0;
        case (q.state)
            SQ_IDLE: begin
                if (start) begin
                    clr_o = 1'b1;
                    if (count_i != '0) begin
                        d.state = SQ_SETUP;
                        d.idx   = '0;
                        d.busy  = 1'b1;
                        d.tms   = cmd_bits_i[0];
                        d.tdi   = cmd_bits_i[1];
                    end
                end
            end
            SQ_SETUP: begin
                d.state = SQ_CLOCK;
                d.tck   = 1'b1;
                d.ph    = '0;
            end
            SQ_CLOCK: begin
                cap_en_o = (q.ph == sd_eff);
                d.ph     = q.ph + PH_W'(1);
                if (q.ph == last_hi) begin
                    d.tck = 1'b0;
                end
                if (q.ph == last_ph) begin
                    if (q.idx == count_i - CNT_W'(1)) begin
                        d.state = SQ_IDLE;
                        d.busy  = 1'b0;
                    end else begin
                        d.state = SQ_SETUP;
                        d.idx   = nxt_idx;
                        d.tms   = cmd_bits_i[bpos];
                        d.tdi   = cmd_bits_i[bpos + IDX_W'(1)];
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: SQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign tck_o     = q.tck;
    assign tms_o     = q.tms;
    assign tdi_o     = q.tdi;
    assign cap_idx_o = q.idx;
endmodule

// File: rtl/jtb_tdo_buf.sv
module jtb_tdo_buf #(
    parameter int DATA_W    = 32,
    parameter int TDO_WORDS = 2,
    parameter int CNT_W     = 6,
    parameter int RD_W      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_en,
    input  logic [CNT_W-1:0]  cap_idx,
    input  logic              tdo,
    input  logic [RD_W-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BUF_W = TDO_WORDS * DATA_W;

    logic [BUF_W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (clr) begin
            bits_d = '0;
        end else if (cap_en) begin
            bits_d[cap_idx] = tdo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < TDO_WORDS; w++) begin
            if (rd_idx == RD_W'(w)) begin
                rd_data = bits_q[w*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/jtag_burst_engine.sv
module jtag_burst_engine #(
    parameter int DATA_W  = 32,
    parameter int MAX_DBL = 57,
    parameter int HP_W    = 8,
    parameter int SD_W    = 8,
    parameter int HP_RST  = 8,
    parameter int SD_RST  = 2,
    localparam int DBL_PER_WORD = DATA_W / 2,
    localparam int CMD_WORDS    = (MAX_DBL + DBL_PER_WORD - 1) / DBL_PER_WORD,
    localparam int TDO_WORDS    = (MAX_DBL + DATA_W - 1) / DATA_W,
    localparam int CNT_W        = $clog2(MAX_DBL + 1),
    localparam int ADDR_W       = $clog2(CMD_WORDS + 3),
    localparam int RD_W         = (TDO_WORDS > 1) ? $clog2(TDO_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    output logic              busy,
    input  logic [RD_W-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    logic [CNT_W-1:0]            count_w;
    logic [CMD_WORDS*DATA_W-1:0] cmd_bits_w;
    logic [HP_W-1:0]             half_w;
    logic [SD_W-1:0]             sdly_w;
    logic                        clr_w, cap_en_w;
    logic [CNT_W-1:0]            cap_idx_w;

    jtb_cmd_regs #(
        .DATA_W(DATA_W), .MAX_DBL(MAX_DBL), .CMD_WORDS(CMD_WORDS), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .HP_W(HP_W), .SD_W(SD_W), .HP_RST(HP_RST), .SD_RST(SD_RST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock(busy), .count_o(count_w), .cmd_bits_o(cmd_bits_w), .half_o(half_w),
        .sdly_o(sdly_w)
    );

    jtb_seq #(
        .CNT_W(CNT_W), .BITS_W(CMD_WORDS*DATA_W), .HP_W(HP_W), .SD_W(SD_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .count_i(count_w), .cmd_bits_i(cmd_bits_w),
        .half_i(half_w), .sdly_i(sdly_w), .busy_o(busy), .tck_o(tck), .tms_o(tms),
        .tdi_o(tdi), .clr_o(clr_w), .cap_en_o(cap_en_w), .cap_idx_o(cap_idx_w)
    );

    jtb_tdo_buf #(
        .DATA_W(DATA_W), .TDO_WORDS(TDO_WORDS), .CNT_W(CNT_W), .RD_W(RD_W)
    ) i_tdo (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .cap_en(cap_en_w), .cap_idx(cap_idx_w),
        .tdo(tdo), .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: rtl/jtb_checker.sv
module jtb_checker #(
    parameter int CNT_W   = 6,
    parameter int HP_W    = 8,
    parameter int MAX_DBL = 57
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tck,
    input logic             tms,
    input logic             tdi,
    input logic             busy,
    input logic             start,
    input logic             wr_en,
    input logic [CNT_W-1:0] count_q,
    input logic [HP_W-1:0]  half_q
);
    localparam int PH_W = HP_W + 1;

    logic [PH_W-1:0] hi_cnt_q, h_eff;

    assign h_eff = (half_q == '0) ? PH_W'(1) : PH_W'(half_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (tck) begin
            hi_cnt_q <= hi_cnt_q + PH_W'(1);
        end else begin
            hi_cnt_q <= '0;
        end
    end

    AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !tck); // R4
    AST_PINS_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) tck |-> ($stable(tms) && $stable(tdi))); // R3
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(tck) |-> (hi_cnt_q == h_eff)); // R4
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && count_q != '0) |=> busy); // R8
    AST_ZERO_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && count_q == '0) |=> !busy); // R10
    AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) count_q <= CNT_W'(MAX_DBL)); // R10
    AST_LOCK_CFG: assert property (@(posedge clk) disable iff (!rst_n) (busy && wr_en) |=> ($stable(half_q) && $stable(count_q))); // R9
    AST_BUSY_END_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (!tck && $past(!tck))); // R8
endmodule

bind jtag_burst_engine jtb_checker #(
    .CNT_W(CNT_W), .HP_W(HP_W), .MAX_DBL(MAX_DBL)
) i_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy),
    .start(start), .wr_en(wr_en), .count_q(count_w), .half_q(half_w)
);

// File: tb/test_jtag_burst_engine.sv
`timescale 1ns/1ps
module test_jtag_burst_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        rd_idx = 1'b0;
    logic [31:0] rd_data;
    logic        tck, tms, tdi;
    logic        tdo = 1'b0;

    int errs = 0;
    int checks = 0;
    logic [127:0] exp_cmd = '0;
    int cur_h = 8;
    int cur_d = 2;
    int cur_cnt = 0;

    always #2.5 clk = ~clk;

    jtag_burst_engine i_jtag_burst_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .busy(busy), .rd_idx(rd_idx), .rd_data(rd_data),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int cnt);
        for (int w = 0; w < 4; w++) exp_cmd[w*32 +: 32] = $urandom;
        wr(0, 32'(cnt));
        for (int w = 0; w < 4; w++) wr(w + 1, exp_cmd[w*32 +: 32]);
        cur_cnt = cnt;
    endtask

    task automatic cfg(input int h, input int d);
        wr(5, 32'(h)); wr(6, 32'(d));
        cur_h = h; cur_d = d;
    endtask

    function automatic int eff_n(input int c); return (c > 57) ? 57 : c; endfunction
    function automatic int eff_h(input int h); return (h == 0) ? 1 : h; endfunction
    function automatic int eff_d(input int d, input int h); return (d > 2*h - 1) ? 2*h - 1 : d; endfunction

    task automatic check_rb(input logic [63:0] exp, input string tag);
        for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            rd_idx = 1'(w);
            #1;
            chk("R6", $sformatf("%s readback word %0d (R5 sample point)", tag, w), rd_data, exp[w*32 +: 32]);
        end
    endtask

    task automatic run(input bit meddle, input string tag);
        int n, h, d, busy_cyc, rises, pin_err, hi_err, c, hi_run, guard;
        bit prev;
        logic [63:0] v, exp_rb;
        n = eff_n(cur_cnt); h = eff_h(cur_h); d = eff_d(cur_d, h);
        v = {$urandom, $urandom};
        exp_rb = '0;
        for (int k = 0; k < n; k++) exp_rb[k] = v[k];
        busy_cyc = 0; rises = 0; pin_err = 0; hi_err = 0; c = 0; hi_run = 0; guard = 0; prev = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy && guard < 20000) begin
            busy_cyc++;
            guard++;
            if (tck && !prev) begin
                c = 0;
                if (tms !== exp_cmd[2*rises] || tdi !== exp_cmd[2*rises + 1]) pin_err++;
                rises++;
                hi_run = 1;
            end else begin
                c++;
                if (tck) hi_run++;
                else if (prev && hi_run != h) hi_err++;
            end
            if (rises > 0) tdo = (c == d) ? v[rises-1] : ~v[rises-1];
            else tdo = 1'b0;
            if (meddle) begin
                wr_en = 1'b0; start = 1'b0;
                if (busy_cyc == 3) begin start = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = ~exp_cmd[31:0]; end
                if (busy_cyc == 4) begin wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'(cur_h + 3); end
                if (busy_cyc == 5) begin start = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'd1; end
            end
            prev = tck;
            @(negedge clk);
        end
        wr_en = 1'b0; start = 1'b0; tdo = 1'b0;
        chk("R8", {tag, " busy cycles"}, busy_cyc, n * (2*h + 1));
        chk("R4", {tag, " TCK pulse count"}, rises, n);
        chk("R4", {tag, " TCK high widths off"}, hi_err, 0);
        chk("R3", {tag, " TMS/TDI doublet mismatches"}, pin_err, 0);
        chk("R8", {tag, " TCK low after busy"}, tck, 0);
        check_rb(exp_rb, tag);
    endtask

    initial begin
        #(150000 * 5);
        errs++; checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "tck after reset", tck, 0);
        chk("R1", "tms/tdi after reset", {tms, tdi}, 0);
        check_rb('0, "R1 reset");

        // defaults: half period 8, sample delay 2
        load(57);
        run(1'b0, "R1 defaults");

        for (int i = 0; i < 6; i++) begin
            int h;
            h = 1 + int'($urandom % 12);
            load(int'($urandom % 58));
            cfg(h, int'($urandom % (2*h + 4)));
            run(1'b0, $sformatf("R5 random %0d", i));
        end

        // half period zero acts as one, delay 0
        load(40); cfg(0, 0);
        run(1'b0, "R4 half zero");
        // delay well past the pulse: limited to 2H-1
        load(33); cfg(3, 200);
        run(1'b0, "R5 delay clamp");

        // count zero after a burst that left bits: clears, no activity
        load(0);
        run(1'b0, "R10 zero count");
        chk("R7", "buffer cleared by zero-count start word0", rd_data, 0);

        // counts above the limit
        load(100); cfg(2, 1);
        run(1'b0, "R10 count 100");
        load(64);
        run(1'b0, "R10 count 64");

        // writes and starts during busy are ignored
        load(20); cfg(2, 2);
        run(1'b1, "R9 meddled burst");
        wr(7, $urandom);
        run(1'b0, "R9 rerun no reload (R2 addr 7)");

        // new burst overwrites older bits
        load(5);
        run(1'b0, "R7 short after long");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule